// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the timing enables for a UART from a fast reference clock. The reference clock is first slowed by a small integer pre-divider. The pre-divider ratio comes from a 3-bit code whose mapping is not monotonic. A phase accumulator then scales the pre-divided rate by a programmable ratio, increment over modulus, and produces a single-cycle 16x oversampling tick. A 4-bit counter reduces that tick to a single-cycle bit-rate enable.

Software writes three fields through a simple write port: the pre-divider code, the increment and the modulus. The increment and modulus registers each hold their value minus one. A new ratio takes hold only when an increment write is followed directly by a modulus write. A half-finished update therefore never disturbs the running rate. When a new ratio takes hold, the phase accumulator is cleared, so the first tick under the new ratio starts from a known phase. With an increment field of 15 and a modulus field of N-1, the bit-rate enable comes every N reference clocks. This gives the usual way to program a baud rate.

Top module: `frac_baud_tick`

## Requirements
- R1: While `rst_n` is low, `tick16_o` and `bit_en_o` are 0. After release, the register defaults are pre-divider code 5 (divide by 1), increment field 15 and modulus field 15, so `tick16_o` is high on every clock.
- R2: Pre-divider codes 0, 1, 2, 3, 4, 5, 6 and 7 give divide ratios 6, 5, 4, 3, 2, 1, 7 and 1. The pre-divider code is written at `cfg_addr` 0 from `cfg_wdata[2:0]` and applies at once. With increment equal to modulus, one tick comes every ratio clocks.
- R3: With I = increment field + 1, M = modulus field + 1, I <= M and pre-divide ratio P, `tick16_o` pulses exactly I times in every window of P*M consecutive clocks.
- R4: With code 5 or 7, an increment field of 15 and a modulus field of N-1 (N >= 16), `bit_en_o` pulses exactly every N clocks.
- R5: A write to `cfg_addr` 1 (increment) stages a value. A write to `cfg_addr` 2 (modulus) commits the staged increment together with the modulus when it is the next write after the increment write. Idle cycles with no write in between are allowed.
- R6: The active ratio stays unchanged after an increment write with no modulus write following, after an increment write followed by a write to any other address, and after a modulus write not preceded by an increment write.
- R7: If I > M, `tick16_o` pulses on every pre-divided cycle.
- R8: `bit_en_o` pulses together with every sixteenth `tick16_o` pulse and never without one.
- R9: A commit clears the phase. `tick16_o` is 0 in the cycle after the commit edge. With divide ratio 1, the first tick appears after ceil(M/I) clocks, counted from the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 pre-divider code, 1 increment, 2 modulus, 3 unused |
| cfg_wdata | input | DIV_W | Write data |
| tick16_o | output | 1 | Single-cycle 16x oversampling enable |
| bit_en_o | output | 1 | Single-cycle bit-rate enable |

## Verification
The hardest situation to reach from the ports is a broken commit sequence. An increment write must be staged and then defeated by an intervening write or by a lone modulus write. The modulus value used must be one that would visibly change the tick density if it were wrongly accepted. The bench first sets a known ratio, then makes each broken sequence, and then counts ticks over a full ratio period, where a wrong commit would change the count. The phase clearing on commit is checked by looking for the first tick on an exact cycle after a pair of writes.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  localparam int PRE_CODE_W = 3;
  localparam int PRE_RATIO_W = 3;

  typedef enum logic [1:0] {
    ADDR_PRE  = 2'd0,
    ADDR_INC  = 2'd1,
    ADDR_MOD  = 2'd2,
    ADDR_NONE = 2'd3
  } cfg_addr_e;

  // Non-monotonic code to ratio map; the top code falls back to 1.
  function automatic logic [PRE_RATIO_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
    logic [PRE_RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 3'd6;
      3'd1:    r = 3'd5;
      3'd2:    r = 3'd4;
      3'd3:    r = 3'd3;
      3'd4:    r = 3'd2;
      3'd5:    r = 3'd1;
      3'd6:    r = 3'd7;
      default: r = 3'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/frac_cfg_regs.sv
module frac_cfg_regs
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [1:0]            addr,
  input  logic [DIV_W-1:0]      wdata,
  output logic [PRE_CODE_W-1:0] pre_code,
  output logic                  pre_wr,
  output logic [DIV_W-1:0]      act_inc,
  output logic [DIV_W-1:0]      act_mod,
  output logic                  commit
);

  localparam logic [DIV_W-1:0] RST_RATIO = DIV_W'(15);
  localparam logic [PRE_CODE_W-1:0] RST_CODE = PRE_CODE_W'(5);

  logic [DIV_W-1:0] inc_stage;
  logic             armed;

  assign pre_wr = we && (cfg_addr_e'(addr) == ADDR_PRE);
  assign commit = we && (cfg_addr_e'(addr) == ADDR_MOD) && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_code  <= RST_CODE;
      inc_stage <= RST_RATIO;
      armed     <= 1'b0;
      act_inc   <= RST_RATIO;
      act_mod   <= RST_RATIO;
    end else if (we) begin
      // Any write re-decides the arm state: only an increment write arms.
      armed <= (cfg_addr_e'(addr) == ADDR_INC);
      if (cfg_addr_e'(addr) == ADDR_INC) inc_stage <= wdata;
      if (pre_wr) pre_code <= wdata[PRE_CODE_W-1:0];
      if (commit) begin
        act_inc <= inc_stage;
        act_mod <= wdata;
      end
    end
  end

endmodule

// File: rtl/frac_prediv.sv
module frac_prediv
  import frac_baud_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRE_CODE_W-1:0] code,
  input  logic                  restart,
  output logic                  strobe
);

  logic [PRE_RATIO_W-1:0] cnt;
  logic [PRE_RATIO_W-1:0] ratio;

  assign ratio  = pre_ratio(code);
  assign strobe = (cnt == (ratio - PRE_RATIO_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (strobe)  cnt <= '0;
    else              cnt <= cnt + PRE_RATIO_W'(1);
  end

endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
  parameter int DIV_W = 16,
  localparam int ACC_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             clear,
  input  logic [DIV_W-1:0] inc_reg,
  input  logic [DIV_W-1:0] mod_reg,
  output logic             tick,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc1;
  logic [ACC_W-1:0] mod1;

  function automatic logic step_fires(input logic [ACC_W-1:0] a,
                                      input logic [ACC_W-1:0] i1,
                                      input logic [ACC_W-1:0] m1);
    return (i1 > m1) || ((a + i1) >= m1);
  endfunction

  function automatic logic [ACC_W-1:0] step_next(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] i1,
                                                 input logic [ACC_W-1:0] m1);
    logic [ACC_W-1:0] s;
    s = a + i1;
    if (i1 > m1)     return '0;
    else if (s >= m1) return s - m1;
    else             return s;
  endfunction

  assign inc1  = ACC_W'(inc_reg) + ACC_W'(1);
  assign mod1  = ACC_W'(mod_reg) + ACC_W'(1);
  assign acc_o = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (clear) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (strobe) begin
      acc  <= step_next(acc, inc1, mod1);
      tick <= step_fires(acc, inc1, mod1);
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/frac_bit_count.sv
module frac_bit_count #(
  parameter int OVS = 16,
  localparam int CNT_W = $clog2(OVS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic bit_en
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_en = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (bit_en)  cnt <= '0;
    else if (tick)    cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16,
  localparam int ACC_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic             tick16_o,
  output logic             bit_en_o
);

  logic [PRE_CODE_W-1:0] pre_code;
  logic                  pre_wr;
  logic [DIV_W-1:0]      act_inc;
  logic [DIV_W-1:0]      act_mod;
  logic                  commit_evt;
  logic                  pre_strobe;
  logic [ACC_W-1:0]      acc_val;

  frac_cfg_regs #(.DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .pre_code(pre_code),
    .pre_wr  (pre_wr),
    .act_inc (act_inc),
    .act_mod (act_mod),
    .commit  (commit_evt)
  );

  frac_prediv u_prediv (
    .clk    (clk),
    .rst_n  (rst_n),
    .code   (pre_code),
    .restart(pre_wr),
    .strobe (pre_strobe)
  );

  frac_phase_acc #(.DIV_W(DIV_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (pre_strobe),
    .clear  (commit_evt),
    .inc_reg(act_inc),
    .mod_reg(act_mod),
    .tick   (tick16_o),
    .acc_o  (acc_val)
  );

  frac_bit_count #(.OVS(OVS)) u_bits (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16_o),
    .bit_en(bit_en_o)
  );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int DIV_W = 16,
  localparam int ACC_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit,
  input logic             strobe,
  input logic             tick,
  input logic             bit_en,
  input logic [ACC_W-1:0] acc,
  input logic [DIV_W-1:0] inc_act,
  input logic [DIV_W-1:0] mod_act
);

  logic [ACC_W-1:0] mod1_c;
  assign mod1_c = ACC_W'(mod_act) + ACC_W'(1);

  a_r9_commit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !tick);

  a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (acc == '0));

  a_r3_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc < mod1_c);

  a_r3_tick_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(strobe));

  a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(inc_act) && $stable(mod_act)));

  a_r7_overflow_every: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_act > mod_act && strobe && !commit) |=> tick);

  a_r8_bit_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> tick);

  a_r8_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en);

endmodule

bind frac_baud_tick frac_baud_chk #(.DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .commit (commit_evt),
  .strobe (pre_strobe),
  .tick   (tick16_o),
  .bit_en (bit_en_o),
  .acc    (acc_val),
  .inc_act(act_inc),
  .mod_act(act_mod)
);

// File: tb/tb_frac_baud_tick.sv
`timescale 1ns/1ps
module tb_frac_baud_tick;

  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = 2'd0;
  logic [DIV_W-1:0] cfg_wdata = '0;
  logic             tick16_o;
  logic             bit_en_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  frac_baud_tick #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick16_o(tick16_o), .bit_en_o(bit_en_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DIV_W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Increment then modulus on consecutive cycles; returns at the negedge after the commit edge.
  task automatic wr_pair(input int inc, input int md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = DIV_W'(inc);
    @(negedge clk);
    cfg_addr = 2'd2; cfg_wdata = DIV_W'(md);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count(input int n, output int t, output int b);
    t = 0; b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t += int'(tick16_o);
      b += int'(bit_en_o);
    end
  endtask

  task automatic t_reset();
    int t, b;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!tick16_o && !bit_en_o, "R1 outputs low in reset", int'(tick16_o), 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    count(16, t, b);
    check(t == 16, "R1 default tick every clock", t, 16);
    count(32, t, b);
    check(b == 2, "R1/R8 default bit enable per 16 ticks", b, 2);
  endtask

  task automatic t_prediv();
    int t, b;
    int ratios[8] = '{6, 5, 4, 3, 2, 1, 7, 1};
    wr_pair(15, 15);
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, c);
      repeat (10) @(negedge clk);
      count(8 * ratios[c], t, b);
      check(t == 8, $sformatf("R2 code %0d ratio %0d", c, ratios[c]), t, 8);
    end
    wr(2'd0, 5);
  endtask

  task automatic t_fraction();
    int t, b;
    wr_pair(2, 9);
    repeat (20) @(negedge clk);
    count(30, t, b);
    check(t == 9, "R3 ratio 3/10 at divide 1", t, 9);
    wr(2'd0, 3);
    repeat (20) @(negedge clk);
    count(60, t, b);
    check(t == 6, "R3 ratio 3/10 at divide 3", t, 6);
    wr(2'd0, 5);
  endtask

  task automatic t_commit_phase();
    wr_pair(15, 15);
    repeat (5) @(negedge clk);
    wr_pair(2, 9);
    check(!tick16_o, "R9 no tick right after commit", int'(tick16_o), 0);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check(tick16_o == (i == 4), $sformatf("R9 first tick at clock 4, clock %0d", i),
            int'(tick16_o), int'(i == 4));
    end
  endtask

  task automatic t_commit_rule();
    int t, b;
    wr_pair(2, 9);
    wr(2'd1, 7);
    repeat (20) @(negedge clk);
    count(20, t, b);
    check(t == 6, "R6 lone increment write ignored", t, 6);
    wr(2'd1, 7);
    wr(2'd0, 5);
    wr(2'd2, 9);
    repeat (20) @(negedge clk);
    count(20, t, b);
    check(t == 6, "R6 increment broken by other write", t, 6);
    wr(2'd1, 7);
    wr(2'd3, 0);
    wr(2'd2, 9);
    repeat (20) @(negedge clk);
    count(20, t, b);
    check(t == 6, "R6 increment broken by unused address", t, 6);
    wr(2'd2, 19);
    repeat (20) @(negedge clk);
    count(20, t, b);
    check(t == 6, "R6 lone modulus write ignored", t, 6);
    wr(2'd1, 4);
    repeat (3) @(negedge clk);
    wr(2'd2, 9);
    repeat (20) @(negedge clk);
    count(20, t, b);
    check(t == 10, "R5 commit with idle gap", t, 10);
    wr_pair(0, 9);
    repeat (20) @(negedge clk);
    count(20, t, b);
    check(t == 2, "R5 back-to-back commit", t, 2);
  endtask

  task automatic t_overflow();
    int t, b;
    wr_pair(20, 9);
    repeat (5) @(negedge clk);
    count(20, t, b);
    check(t == 20, "R7 overflow tick every clock", t, 20);
    wr(2'd0, 3);
    repeat (10) @(negedge clk);
    count(30, t, b);
    check(t == 10, "R7 overflow tick every pre-divided cycle", t, 10);
    wr(2'd0, 5);
  endtask

  task automatic t_integer_baud();
    int t, b, gap;
    bit bad;
    wr_pair(15, 99);
    repeat (30) @(negedge clk);
    count(100, t, b);
    check(t == 16, "R3 sixteen ticks per 100 clocks", t, 16);
    bad = 1'b0;
    b = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bit_en_o) begin
        b++;
        if (!tick16_o) bad = 1'b1;
      end
    end
    check(b == 4, "R4 bit enable count over 400 clocks", b, 4);
    check(!bad, "R8 bit enable coincides with tick", int'(bad), 0);
    while (!bit_en_o) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!bit_en_o && gap < 1000);
    check(gap == 100, "R4 bit enable period", gap, 100);
  endtask

  initial begin
    t_reset();
    t_prediv();
    t_fraction();
    t_commit_phase();
    t_commit_rule();
    t_overflow();
    t_integer_baud();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule